// File: doc/BRIEF.md
# Socket Connection State Controller

This block is the control state machine of a single network socket. A host selects a socket mode (closed, TCP, UDP or raw MAC frames) and writes one-byte commands into a command register. Pulses from the receive path report arriving SYN, SYN+ACK, ACK and FIN segments and a retransmission timeout. The block reports its progress as a fixed status byte that the host can poll. It also raises one-cycle requests for the transmit path to send SYN, SYN+ACK, ACK or FIN segments, and one-cycle event pulses when a connection comes up or a FIN arrives.

Both the client (active open) and server (passive open) handshakes are handled, as are the active close and the passive close. The two halves of the FIN-wait phase appear to the host as one status code. The TIME_WAIT hold is a parameterized cycle count. A close command or a timeout returns the socket to the closed state from anywhere. Building packets, checksums, retransmission and data buffers belong to neighbouring blocks.

Top module: `sock_conn_ctrl`

## Requirements
- R1: After reset, status_o is 0x00, cmd_o is 0x00, and every transmit request and event output is low.
- R2: A byte written with cmd_wr_i reads back on cmd_o for exactly one cycle and then reads 0x00. The command acts at the next clock edge, so the status changes two edges after the write is presented.
- R3: OPEN (0x01) in status 0x00 moves to 0x13 when mode_i is 1 (TCP), to 0x22 when mode_i is 2 (UDP), and to 0x42 when mode_i is 4 (raw MAC). For any other mode value, status stays 0x00.
- R4: Client open: CONNECT (0x04) in status 0x13 enters 0x15 and pulses tx_syn_o. A received SYN+ACK in 0x15 enters 0x17 and pulses tx_ack_o and ev_conn_o.
- R5: Server open: LISTEN (0x02) in status 0x13 enters 0x14. A received SYN there enters 0x16 and pulses tx_synack_o. A received ACK in 0x16 enters 0x17 and pulses ev_conn_o.
- R6: Active close: DISCON (0x08) in 0x17 enters 0x18 and pulses tx_fin_o. From 0x18, the outcome depends on what arrives:
  - ACK, then a later FIN, enters 0x1B.
  - FIN first enters 0x1A; a later ACK enters 0x1B.
  - FIN and ACK in the same cycle enter 0x1B.
  
  Each received FIN pulses tx_ack_o.
- R7: Status 0x1B is held for exactly TW_CYCLES clock cycles and then returns to 0x00.
- R8: Passive close: a FIN received in 0x17 enters 0x1C and pulses tx_ack_o. DISCON in 0x1C enters 0x1D and pulses tx_fin_o. A received ACK in 0x1D enters 0x00.
- R9: ev_fin_o pulses in the cycle after every received FIN that changes the state (in 0x17 or 0x18).
- R10: CLOSE (0x10) or timeout_i forces status 0x00 from any state, ahead of any other input in the same cycle.
- R11: The following commands are ignored and leave the status unchanged with no pulses:
  - LISTEN, CONNECT and DISCON while mode_i is not 1.
  - Any command that is not valid in the current status.
  - The data commands SEND 0x20, SEND_MAC 0x21, SEND_KEEP 0x22 and RECV 0x40.
- R12: A command that takes effect wins over received segments in the same cycle. A received segment that the current status does not expect is ignored.
- R13: Transmit requests last one cycle, and at most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 4 | Socket mode: 0 closed, 1 TCP, 2 UDP, 4 raw MAC |
| cmd_wr_i | input | 1 | Write strobe for the command register |
| cmd_data_i | input | 8 | Command byte |
| rx_syn_i | input | 1 | A SYN segment arrived |
| rx_synack_i | input | 1 | A SYN+ACK segment arrived |
| rx_ack_i | input | 1 | An ACK segment arrived |
| rx_fin_i | input | 1 | A FIN segment arrived |
| timeout_i | input | 1 | Retransmission timeout |
| cmd_o | output | 8 | Command register readback |
| status_o | output | 8 | Encoded socket status |
| tx_syn_o | output | 1 | Request to send SYN |
| tx_synack_o | output | 1 | Request to send SYN+ACK |
| tx_ack_o | output | 1 | Request to send ACK |
| tx_fin_o | output | 1 | Request to send FIN |
| ev_conn_o | output | 1 | Connection reached established |
| ev_fin_o | output | 1 | A FIN was received |

## Verification
The bench targets the FIN-wait phase first, because a design that does not keep its two hidden halves apart would send a FIN-then-ACK sequence straight to TIME_WAIT, or leave FIN+ACK in the same cycle stuck in CLOSING. It counts the TIME_WAIT hold cycle by cycle, where an off-by-one timer shows up as a status that clears a cycle early or late. It issues TCP-only commands in UDP or raw mode, and data commands in every state; a design that does not gate these would move state or pulse a transmit request. It also collides commands with received segments and timeouts, where a wrong priority would pick the wrong next state.

// File: rtl/sock_conn_pkg.sv
package sock_conn_pkg;

    localparam int MODE_W = 4;
    localparam int BYTE_W = 8;

    localparam logic [MODE_W-1:0] MODE_OFF = 4'd0;
    localparam logic [MODE_W-1:0] MODE_TCP = 4'd1;
    localparam logic [MODE_W-1:0] MODE_UDP = 4'd2;
    localparam logic [MODE_W-1:0] MODE_RAW = 4'd4;

    localparam logic [BYTE_W-1:0] OP_OPEN     = 8'h01;
    localparam logic [BYTE_W-1:0] OP_LISTEN   = 8'h02;
    localparam logic [BYTE_W-1:0] OP_CONNECT  = 8'h04;
    localparam logic [BYTE_W-1:0] OP_DISCON   = 8'h08;
    localparam logic [BYTE_W-1:0] OP_CLOSE    = 8'h10;

    localparam logic [BYTE_W-1:0] SC_CLOSED    = 8'h00;
    localparam logic [BYTE_W-1:0] SC_INIT      = 8'h13;
    localparam logic [BYTE_W-1:0] SC_LISTEN    = 8'h14;
    localparam logic [BYTE_W-1:0] SC_SYNSENT   = 8'h15;
    localparam logic [BYTE_W-1:0] SC_SYNRECV   = 8'h16;
    localparam logic [BYTE_W-1:0] SC_ESTAB     = 8'h17;
    localparam logic [BYTE_W-1:0] SC_FINWAIT   = 8'h18;
    localparam logic [BYTE_W-1:0] SC_CLOSING   = 8'h1A;
    localparam logic [BYTE_W-1:0] SC_TIMEWAIT  = 8'h1B;
    localparam logic [BYTE_W-1:0] SC_CLOSEWAIT = 8'h1C;
    localparam logic [BYTE_W-1:0] SC_LASTACK   = 8'h1D;
    localparam logic [BYTE_W-1:0] SC_UDP       = 8'h22;
    localparam logic [BYTE_W-1:0] SC_RAW       = 8'h42;

    typedef enum logic [3:0] {
        ST_CLOSED, ST_INIT, ST_LISTEN, ST_SYNSENT, ST_SYNRECV, ST_ESTAB,
        ST_FINW_A, ST_FINW_B, ST_CLOSING, ST_TIMEWAIT, ST_CLOSEWAIT,
        ST_LASTACK, ST_UDP, ST_RAW
    } conn_state_e;

    typedef struct packed {
        logic open;
        logic listen;
        logic connect;
        logic discon;
        logic close;
    } cmd_req_t;

    function automatic logic [BYTE_W-1:0] status_code(conn_state_e s);
        logic [BYTE_W-1:0] c;
        case (s)
            ST_INIT:      c = SC_INIT;
            ST_LISTEN:    c = SC_LISTEN;
            ST_SYNSENT:   c = SC_SYNSENT;
            ST_SYNRECV:   c = SC_SYNRECV;
            ST_ESTAB:     c = SC_ESTAB;
            ST_FINW_A,
            ST_FINW_B:    c = SC_FINWAIT;
            ST_CLOSING:   c = SC_CLOSING;
            ST_TIMEWAIT:  c = SC_TIMEWAIT;
            ST_CLOSEWAIT: c = SC_CLOSEWAIT;
            ST_LASTACK:   c = SC_LASTACK;
            ST_UDP:       c = SC_UDP;
            ST_RAW:       c = SC_RAW;
            default:      c = SC_CLOSED;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sock_cmd_reg.sv
module sock_cmd_reg
    import sock_conn_pkg::*;
#(
    parameter int CMD_W  = BYTE_W,
    parameter int MODE_BITS = MODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic [CMD_W-1:0]     data_i,
    input  logic [MODE_BITS-1:0] mode_i,
    output logic [CMD_W-1:0]     cmd_o,
    output cmd_req_t             req_o
);
    logic [CMD_W-1:0] cmd_d, cmd_q;
    logic             is_tcp;

    // The register holds a written byte for one cycle, then clears itself.
    always_comb begin
        cmd_d = wr_i ? data_i : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    // Decode; connection-level commands need TCP mode.
    always_comb begin
        is_tcp         = (mode_i == MODE_BITS'(MODE_TCP));
        req_o.open     = (cmd_q == CMD_W'(OP_OPEN));
        req_o.listen   = (cmd_q == CMD_W'(OP_LISTEN))  && is_tcp;
        req_o.connect  = (cmd_q == CMD_W'(OP_CONNECT)) && is_tcp;
        req_o.discon   = (cmd_q == CMD_W'(OP_DISCON))  && is_tcp;
        req_o.close    = (cmd_q == CMD_W'(OP_CLOSE));
    end

    assign cmd_o = cmd_q;

endmodule

// File: rtl/sock_tw_timer.sv
module sock_tw_timer #(
    parameter int TW_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CNT_W = $clog2(TW_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TW_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = run_i ? cnt_q + 1'b1 : '0;
        done_o = run_i && (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/sock_conn_fsm.sv
module sock_conn_fsm
    import sock_conn_pkg::*;
#(
    parameter int MODE_BITS = MODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  cmd_req_t             req_i,
    input  logic [MODE_BITS-1:0] mode_i,
    input  logic                 rx_syn_i,
    input  logic                 rx_synack_i,
    input  logic                 rx_ack_i,
    input  logic                 rx_fin_i,
    input  logic                 timeout_i,
    input  logic                 tw_done_i,
    output conn_state_e          state_o,
    output logic                 tx_syn_o,
    output logic                 tx_synack_o,
    output logic                 tx_ack_o,
    output logic                 tx_fin_o,
    output logic                 ev_conn_o,
    output logic                 ev_fin_o
);
    typedef struct packed {
        conn_state_e st;
        logic        tx_syn;
        logic        tx_synack;
        logic        tx_ack;
        logic        tx_fin;
        logic        ev_conn;
        logic        ev_fin;
    } fsm_t;

    fsm_t s_d, s_q;
    logic cmd_hit;

    always_comb begin
        s_d       = '0;
        s_d.st    = s_q.st;
        cmd_hit   = 1'b0;

        if (timeout_i || req_i.close) begin
            s_d.st = ST_CLOSED;
        end else begin
            // Host commands first.
            case (s_q.st)
                ST_CLOSED: if (req_i.open) begin
                    cmd_hit = 1'b1;
                    case (mode_i)
                        MODE_BITS'(MODE_TCP): s_d.st = ST_INIT;
                        MODE_BITS'(MODE_UDP): s_d.st = ST_UDP;
                        MODE_BITS'(MODE_RAW): s_d.st = ST_RAW;
                        default:              cmd_hit = 1'b0;
                    endcase
                end
                ST_INIT: begin
                    if (req_i.connect) begin
                        cmd_hit    = 1'b1;
                        s_d.st     = ST_SYNSENT;
                        s_d.tx_syn = 1'b1;
                    end else if (req_i.listen) begin
                        cmd_hit = 1'b1;
                        s_d.st  = ST_LISTEN;
                    end
                end
                ST_ESTAB: if (req_i.discon) begin
                    cmd_hit    = 1'b1;
                    s_d.st     = ST_FINW_A;
                    s_d.tx_fin = 1'b1;
                end
                ST_CLOSEWAIT: if (req_i.discon) begin
                    cmd_hit    = 1'b1;
                    s_d.st     = ST_LASTACK;
                    s_d.tx_fin = 1'b1;
                end
                default: cmd_hit = 1'b0;
            endcase

            // Received segments when no command acted.
            if (!cmd_hit) begin
                case (s_q.st)
                    ST_SYNSENT: if (rx_synack_i) begin
                        s_d.st      = ST_ESTAB;
                        s_d.tx_ack  = 1'b1;
                        s_d.ev_conn = 1'b1;
                    end
                    ST_LISTEN: if (rx_syn_i) begin
                        s_d.st        = ST_SYNRECV;
                        s_d.tx_synack = 1'b1;
                    end
                    ST_SYNRECV: if (rx_ack_i) begin
                        s_d.st      = ST_ESTAB;
                        s_d.ev_conn = 1'b1;
                    end
                    ST_ESTAB: if (rx_fin_i) begin
                        s_d.st     = ST_CLOSEWAIT;
                        s_d.tx_ack = 1'b1;
                        s_d.ev_fin = 1'b1;
                    end
                    ST_FINW_A: begin
                        if (rx_fin_i) begin
                            s_d.st     = rx_ack_i ? ST_TIMEWAIT : ST_CLOSING;
                            s_d.tx_ack = 1'b1;
                            s_d.ev_fin = 1'b1;
                        end else if (rx_ack_i) begin
                            s_d.st = ST_FINW_B;
                        end
                    end
                    ST_FINW_B: if (rx_fin_i) begin
                        s_d.st     = ST_TIMEWAIT;
                        s_d.tx_ack = 1'b1;
                        s_d.ev_fin = 1'b1;
                    end
                    ST_CLOSING: if (rx_ack_i) s_d.st = ST_TIMEWAIT;
                    ST_LASTACK: if (rx_ack_i) s_d.st = ST_CLOSED;
                    ST_TIMEWAIT: if (tw_done_i) s_d.st = ST_CLOSED;
                    default: s_d.st = s_q.st;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign state_o     = s_q.st;
    assign tx_syn_o    = s_q.tx_syn;
    assign tx_synack_o = s_q.tx_synack;
    assign tx_ack_o    = s_q.tx_ack;
    assign tx_fin_o    = s_q.tx_fin;
    assign ev_conn_o   = s_q.ev_conn;
    assign ev_fin_o    = s_q.ev_fin;

endmodule

// File: rtl/sock_conn_ctrl.sv
module sock_conn_ctrl
    import sock_conn_pkg::*;
#(
    parameter int TW_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode_i,
    input  logic       cmd_wr_i,
    input  logic [7:0] cmd_data_i,
    input  logic       rx_syn_i,
    input  logic       rx_synack_i,
    input  logic       rx_ack_i,
    input  logic       rx_fin_i,
    input  logic       timeout_i,
    output logic [7:0] cmd_o,
    output logic [7:0] status_o,
    output logic       tx_syn_o,
    output logic       tx_synack_o,
    output logic       tx_ack_o,
    output logic       tx_fin_o,
    output logic       ev_conn_o,
    output logic       ev_fin_o
);
    cmd_req_t    req;
    conn_state_e state;
    logic        tw_done;

    sock_cmd_reg #(.CMD_W(BYTE_W), .MODE_BITS(MODE_W)) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (cmd_wr_i),
        .data_i (cmd_data_i),
        .mode_i (mode_i),
        .cmd_o  (cmd_o),
        .req_o  (req)
    );

    sock_tw_timer #(.TW_CYCLES(TW_CYCLES)) u_tw (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state == ST_TIMEWAIT),
        .done_o (tw_done)
    );

    sock_conn_fsm #(.MODE_BITS(MODE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .mode_i      (mode_i),
        .rx_syn_i    (rx_syn_i),
        .rx_synack_i (rx_synack_i),
        .rx_ack_i    (rx_ack_i),
        .rx_fin_i    (rx_fin_i),
        .timeout_i   (timeout_i),
        .tw_done_i   (tw_done),
        .state_o     (state),
        .tx_syn_o    (tx_syn_o),
        .tx_synack_o (tx_synack_o),
        .tx_ack_o    (tx_ack_o),
        .tx_fin_o    (tx_fin_o),
        .ev_conn_o   (ev_conn_o),
        .ev_fin_o    (ev_fin_o)
    );

    assign status_o = status_code(state);

endmodule

// File: rtl/sock_conn_chk.sv
module sock_conn_chk #(
    parameter int TW_CYCLES = 1000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr_i,
    input logic       timeout_i,
    input logic [7:0] cmd_o,
    input logic [7:0] status_o,
    input logic       tx_syn_o,
    input logic       tx_synack_o,
    input logic       tx_ack_o,
    input logic       tx_fin_o,
    input logic       ev_conn_o,
    input logic       ev_fin_o
);
    int tw_run;

    always_ff @(posedge clk) begin
        if (!rst_n)                 tw_run <= 0;
        else if (status_o == 8'h1B) tw_run <= tw_run + 1;
        else                        tw_run <= 0;
    end

    assert_cmd_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != 8'h00 && !cmd_wr_i) |=> (cmd_o == 8'h00));

    assert_tw_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tw_run <= TW_CYCLES);

    assert_timeout_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_i |=> (status_o == 8'h00));

    assert_tx_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_syn_o, tx_synack_o, tx_ack_o, tx_fin_o}));

    assert_syn_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_syn_o |-> (status_o == 8'h15));

    assert_conn_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_conn_o |-> (status_o == 8'h17));

    assert_fin_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fin_o |-> (status_o == 8'h18 || status_o == 8'h1D));

    assert_fin_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fin_o |-> tx_ack_o);

endmodule

bind sock_conn_ctrl sock_conn_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr_i    (cmd_wr_i),
    .timeout_i   (timeout_i),
    .cmd_o       (cmd_o),
    .status_o    (status_o),
    .tx_syn_o    (tx_syn_o),
    .tx_synack_o (tx_synack_o),
    .tx_ack_o    (tx_ack_o),
    .tx_fin_o    (tx_fin_o),
    .ev_conn_o   (ev_conn_o),
    .ev_fin_o    (ev_fin_o)
);

// File: tb/sock_conn_ctrl_tb.sv
module sock_conn_ctrl_tb_top;
    localparam int TW = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode_r = 4'd0;
    logic       wr_r = 1'b0;
    logic [7:0] data_r = 8'h00;
    logic       syn_r = 1'b0, sa_r = 1'b0, ack_r = 1'b0, fin_r = 1'b0, to_r = 1'b0;
    logic [7:0] cmd_o, status_o;
    logic       tx_syn_o, tx_synack_o, tx_ack_o, tx_fin_o, ev_conn_o, ev_fin_o;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model state
    logic [7:0] m_st = 8'h00;
    logic       m_fw2 = 1'b0;
    int         m_tw = 0;
    logic [7:0] m_cmd = 8'h00;

    always #4 clk = ~clk;

    sock_conn_ctrl #(.TW_CYCLES(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_r),
        .cmd_wr_i(wr_r), .cmd_data_i(data_r),
        .rx_syn_i(syn_r), .rx_synack_i(sa_r), .rx_ack_i(ack_r), .rx_fin_i(fin_r),
        .timeout_i(to_r), .cmd_o(cmd_o), .status_o(status_o),
        .tx_syn_o(tx_syn_o), .tx_synack_o(tx_synack_o), .tx_ack_o(tx_ack_o),
        .tx_fin_o(tx_fin_o), .ev_conn_o(ev_conn_o), .ev_fin_o(ev_fin_o)
    );

    initial begin
        #(8 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end (actual hung, expected done)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    function automatic logic [7:0] open_target(logic [3:0] md);
        case (md)
            4'd1:    return 8'h13;
            4'd2:    return 8'h22;
            4'd4:    return 8'h42;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [21:0] actual_vec();
        return {cmd_o, status_o, tx_syn_o, tx_synack_o, tx_ack_o, tx_fin_o,
                ev_conn_o, ev_fin_o};
    endfunction

    // Computes the expected outputs after the next edge and advances the model.
    task automatic model_cycle(output logic [21:0] exp_v);
        logic [7:0] c = m_cmd;
        logic tcp = (mode_r == 4'd1);
        logic hit = 1'b0;
        logic [7:0] nst = m_st;
        logic nfw2 = m_fw2;
        logic p_syn = 0, p_sa = 0, p_ack = 0, p_fin = 0, e_con = 0, e_fin = 0;
        if (to_r || c == 8'h10) begin
            nst = 8'h00;
        end else begin
            if (m_st == 8'h00 && c == 8'h01 && open_target(mode_r) != 8'h00) begin
                hit = 1; nst = open_target(mode_r);
            end else if (m_st == 8'h13 && c == 8'h04 && tcp) begin
                hit = 1; nst = 8'h15; p_syn = 1;
            end else if (m_st == 8'h13 && c == 8'h02 && tcp) begin
                hit = 1; nst = 8'h14;
            end else if (m_st == 8'h17 && c == 8'h08 && tcp) begin
                hit = 1; nst = 8'h18; nfw2 = 0; p_fin = 1;
            end else if (m_st == 8'h1C && c == 8'h08 && tcp) begin
                hit = 1; nst = 8'h1D; p_fin = 1;
            end
            if (!hit) begin
                case (m_st)
                    8'h15: if (sa_r) begin nst = 8'h17; p_ack = 1; e_con = 1; end
                    8'h14: if (syn_r) begin nst = 8'h16; p_sa = 1; end
                    8'h16: if (ack_r) begin nst = 8'h17; e_con = 1; end
                    8'h17: if (fin_r) begin nst = 8'h1C; p_ack = 1; e_fin = 1; end
                    8'h18: begin
                        if (!m_fw2) begin
                            if (fin_r) begin
                                nst = ack_r ? 8'h1B : 8'h1A; p_ack = 1; e_fin = 1;
                            end else if (ack_r) nfw2 = 1;
                        end else if (fin_r) begin
                            nst = 8'h1B; p_ack = 1; e_fin = 1;
                        end
                    end
                    8'h1A: if (ack_r) nst = 8'h1B;
                    8'h1D: if (ack_r) nst = 8'h00;
                    8'h1B: if (m_tw == TW - 1) nst = 8'h00;
                    default: ;
                endcase
            end
        end
        m_tw  = (m_st == 8'h1B && nst == 8'h1B) ? m_tw + 1 : 0;
        m_st  = nst;
        m_fw2 = nfw2;
        m_cmd = wr_r ? data_r : 8'h00;
        exp_v = {m_cmd, nst, p_syn, p_sa, p_ack, p_fin, e_con, e_fin};
    endtask

    task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual cmd/st/tx/ev=%h expected %h", req, act, exp_v);
        end
    endtask

    // One clock: drive at the current falling edge, sample at the next.
    task automatic step(input string req, input logic wr, input logic [7:0] d,
                        input logic syn, input logic sa, input logic ack,
                        input logic fin, input logic to);
        logic [21:0] exp_v;
        wr_r = wr; data_r = d; syn_r = syn; sa_r = sa; ack_r = ack; fin_r = fin; to_r = to;
        model_cycle(exp_v);
        @(negedge clk);
        wr_r = 0; syn_r = 0; sa_r = 0; ack_r = 0; fin_r = 0; to_r = 0;
        check(req, actual_vec(), exp_v);
    endtask

    task automatic cmd(input string req, input logic [7:0] d);
        step(req, 1, d, 0, 0, 0, 0, 0);
        step(req, 0, 8'h00, 0, 0, 0, 0, 0);
    endtask

    task automatic rx(input string req, input logic syn, input logic sa,
                      input logic ack, input logic fin);
        step(req, 0, 8'h00, syn, sa, ack, fin, 0);
    endtask

    task automatic idle(input string req, input int n);
        for (int i = 0; i < n; i++) step(req, 0, 8'h00, 0, 0, 0, 0, 0);
    endtask

    initial begin
        logic [7:0] ops [10] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                                 8'h20, 8'h21, 8'h22, 8'h40, 8'h01};
        logic [3:0] modes [5] = '{4'd0, 4'd1, 4'd1, 4'd2, 4'd4};
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 reset", actual_vec(), 22'h0);

        // R3 / R11: open by mode, ignored commands
        mode_r = 4'd0; cmd("R3 open mode0 ignored", 8'h01);
        mode_r = 4'd4; cmd("R3 open raw", 8'h01);
        cmd("R10 close raw", 8'h10);
        mode_r = 4'd2; cmd("R3 open udp", 8'h01);
        cmd("R11 send ignored", 8'h20);
        cmd("R11 connect in udp ignored", 8'h04);
        step("R10 timeout udp", 0, 8'h00, 0, 0, 0, 0, 1);

        // R4 client open, R12 unexpected segment, R8 passive close
        mode_r = 4'd1; cmd("R3 open tcp", 8'h01);
        cmd("R11 discon in init ignored", 8'h08);
        cmd("R4 connect", 8'h04);
        rx("R12 ack in synsent ignored", 0, 0, 1, 0);
        rx("R4 synack", 0, 1, 0, 0);
        cmd("R11 send_keep ignored", 8'h22);
        rx("R8 R9 fin in estab", 0, 0, 0, 1);
        cmd("R8 discon closewait", 8'h08);
        rx("R8 ack lastack", 0, 0, 1, 0);

        // R5 server open, R6 ack-then-fin, R7 hold
        cmd("R3 open tcp", 8'h01);
        cmd("R5 listen", 8'h02);
        rx("R5 syn", 1, 0, 0, 0);
        rx("R5 ack", 0, 0, 1, 0);
        cmd("R6 discon", 8'h08);
        rx("R6 ack fw", 0, 0, 1, 0);
        rx("R6 R9 fin after ack", 0, 0, 0, 1);
        idle("R7 timewait hold", TW + 2);

        // R6 fin-first through closing, then simultaneous fin+ack
        cmd("R3 open", 8'h01); cmd("R4 connect", 8'h04); rx("R4 synack", 0, 1, 0, 0);
        cmd("R6 discon", 8'h08);
        rx("R6 fin first", 0, 0, 0, 1);
        rx("R6 ack closing", 0, 0, 1, 0);
        step("R10 timeout in timewait", 0, 8'h00, 0, 0, 0, 0, 1);
        cmd("R3 open", 8'h01); cmd("R5 listen", 8'h02); rx("R5 syn", 1, 0, 0, 0);
        rx("R5 ack", 0, 0, 1, 0);
        cmd("R6 discon", 8'h08);
        rx("R6 fin+ack same cycle", 0, 0, 1, 1);
        idle("R7 timewait hold", TW + 1);

        // R11 mode gating in estab, R12 command vs segment
        cmd("R3 open", 8'h01); cmd("R4 connect", 8'h04); rx("R4 synack", 0, 1, 0, 0);
        mode_r = 4'd2; cmd("R11 discon non-tcp ignored", 8'h08);
        mode_r = 4'd1;
        step("R12 discon write", 1, 8'h08, 0, 0, 0, 0, 0);
        step("R12 discon beats fin", 0, 8'h00, 0, 0, 0, 1, 0);
        step("R10 close write", 1, 8'h10, 0, 0, 0, 0, 0);
        step("R10 close beats ack", 0, 8'h00, 0, 0, 1, 1, 0);
        cmd("R2 R10 close when closed", 8'h10);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom % 100);
            if ($urandom % 25 == 0) mode_r = modes[$urandom % 5];
            if (r < 30)
                step("R2 R11 random cmd", 1, ops[$urandom % 10], 0, 0, 0, 0, 0);
            else if (r < 85)
                step("R13 random rx", 0, 8'h00, ($urandom % 3) == 0, ($urandom % 3) == 0,
                     ($urandom % 2) == 0, ($urandom % 3) == 0, 0);
            else if (r < 87)
                step("R10 random timeout", 0, 8'h00, 0, 0, 0, 0, 1);
            else
                step("R7 random idle", 0, 8'h00, 0, 0, 0, 0, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule